// File: doc/BRIEF.md
# Multi-Thread Instruction Line Requester

This block sits between the fetch logic of a multi-threaded core and the instruction memory port. Each thread owns a one-line buffer holding a tag, a valid bit and the line data. A fetch PC is rounded down to its line boundary. If the owning thread's buffer already holds that line, the lookup completes in the same cycle. If not, a whole-line read goes out on a valid/ready request port, carrying the thread number and a per-thread request tag.

A refused request is parked in one retry slot shared by all threads. While that slot is in use, the port counts as blocked and no new line request is started. The slot is presented again every cycle until the port takes it. A squash of a thread abandons that thread's outstanding request. If the parked request belongs to that thread, the slot is emptied as well. A response whose tag and thread no longer match a live request is thrown away.

Top module: `fetch_line_requester`

## Requirements
- R1: The line address on `mem_req_addr` is the fetch PC with its low log2(LINE_BYTES) bits forced to zero (LINE_BYTES=16 clears bits 3:0).
- R2: A lookup from a ready thread whose buffer is valid and whose stored line address equals the aligned PC raises `fetch_hit` in the same cycle, presents that buffer on `fetch_line`, and starts no memory request.
- R3: No hit and no new request happen, and `fetch_gated` rises for a valid lookup, while the port is blocked, while `switched_out` is high, or while `intr_pending` is high and PC bits 1:0 are both zero.
- R4: A new request drives `mem_req_valid` in the lookup cycle with the thread's request tag plus one (modulo 2^RTAG_W). From the next cycle on, the thread's buffer holds the new line address and its valid bit is clear.
- R5: A new request that the port refuses without `mem_req_bad` moves the thread to state 1 (wait for retry), fills the shared retry slot and sets `cache_blocked` from the next cycle.
- R6: While blocked with a held slot, the held address, thread and tag are presented every cycle. When `mem_req_ready` is high, the owning thread moves to state 2 (wait for response) and `cache_blocked` clears on the next cycle. Thread state encoding: 0 ready, 1 wait for retry, 2 wait for response.
- R7: A squash returns the thread to state 0 and clears its fault. If the thread owns the retry slot, the slot is emptied. The first cycle with `mem_req_ready` high then clears `cache_blocked`, and the squashed request is never sent.
- R8: A response to a thread in state 2 whose tag equals that thread's current tag, with no squash of that thread in the same cycle, writes the line data, sets the buffer valid and returns the thread to state 0.
- R9: Any other response is discarded and pulses `rsp_dropped` in that cycle. It leaves the buffer and the thread state unchanged.
- R10: A new request refused with `mem_req_bad` high sets the thread's fault bit, leaves the thread in state 0 and leaves the retry slot and `cache_blocked` untouched.
- R11: A lookup from a thread not in state 0, or from a thread squashed in the same cycle, is ignored: no hit and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| switched_out | input | 1 | Unit handed off; holds all lookups |
| intr_pending | input | 1 | Interrupt waiting; holds lookups at PCs with bits 1:0 zero |
| fetch_valid | input | 1 | Lookup request this cycle |
| fetch_tid | input | TID_W | Thread of the lookup |
| fetch_pc | input | ADDR_W | Fetch PC of the lookup |
| fetch_hit | output | 1 | Lookup served from the thread's buffer |
| fetch_gated | output | 1 | Lookup held off by the block/switch/interrupt rule |
| fetch_line | output | LINE_W | Buffer contents of the looked-up thread |
| squash_valid | input | 1 | Squash a thread this cycle |
| squash_tid | input | TID_W | Thread to squash |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_addr | output | ADDR_W | Line-aligned request address |
| mem_req_tid | output | TID_W | Requesting thread |
| mem_req_rtag | output | RTAG_W | Request tag |
| mem_req_ready | input | 1 | Port accepts the request |
| mem_req_bad | input | 1 | Refusal carries a bad-address error |
| mem_rsp_valid | input | 1 | Line response valid |
| mem_rsp_tid | input | TID_W | Thread of the response |
| mem_rsp_rtag | input | RTAG_W | Tag of the response |
| mem_rsp_data | input | LINE_W | Line data |
| cache_blocked | output | 1 | Retry slot in use; new requests held |
| thread_state | output | 2*NUM_THREADS | Per-thread state, 2 bits each |
| line_valid | output | NUM_THREADS | Per-thread buffer valid |
| thread_fault | output | NUM_THREADS | Per-thread bad-address fault |
| rsp_dropped | output | 1 | A response was discarded this cycle |

## Verification
Two pairs of events can fall in the same cycle. The first is a squash and a matching response for the same thread. The bench drives both with the thread's live tag and expects `rsp_dropped` with no fill. The second is a squash of the slot owner and a `mem_req_ready` that would otherwise grant its retry. Here the bench expects `mem_req_valid` low, the block cleared on the next cycle and the thread back in state 0. A behavioural model computes both outcomes alongside a concurrent issue on one thread and a fill on another, and compares every output on every clock.

// File: rtl/fetch_line_pkg.sv
package fetch_line_pkg;

  typedef enum logic [1:0] {
    TS_READY      = 2'd0,
    TS_WAIT_RETRY = 2'd1,
    TS_WAIT_RSP   = 2'd2
  } thr_state_e;

  // lookups at word-aligned PCs stall while an interrupt is waiting
  function automatic logic intr_hold(input logic pend, input logic [1:0] pc_lo);
    return pend && (pc_lo == 2'b00);
  endfunction

endpackage

// File: rtl/fl_line_store.sv
module fl_line_store #(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_W      = 128,
  parameter int TID_W       = 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 inv_en,
  input  logic [TID_W-1:0]                     inv_tid,
  input  logic [ADDR_W-1:0]                    inv_addr,
  input  logic                                 fill_en,
  input  logic [TID_W-1:0]                     fill_tid,
  input  logic [LINE_W-1:0]                    fill_data,
  output logic [NUM_THREADS-1:0][ADDR_W-1:0]   tag_o,
  output logic [NUM_THREADS-1:0]               valid_o,
  output logic [NUM_THREADS-1:0][LINE_W-1:0]   data_o
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_buf
    logic inv_here, fill_here;
    assign inv_here  = inv_en  && (inv_tid  == TID_W'(t));
    assign fill_here = fill_en && (fill_tid == TID_W'(t));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_o[t]   <= '0;
        valid_o[t] <= 1'b0;
        data_o[t]  <= '0;
      end else if (inv_here) begin
        tag_o[t]   <= inv_addr;
        valid_o[t] <= 1'b0;
      end else if (fill_here) begin
        data_o[t]  <= fill_data;
        valid_o[t] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fl_retry_slot.sv
module fl_retry_slot #(
  parameter int ADDR_W = 32,
  parameter int TID_W  = 1,
  parameter int RTAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [TID_W-1:0]  load_tid,
  input  logic [RTAG_W-1:0] load_rtag,
  input  logic              drop,
  input  logic              port_ready,
  output logic              held,
  output logic              blocked,
  output logic [ADDR_W-1:0] addr,
  output logic [TID_W-1:0]  tid,
  output logic [RTAG_W-1:0] rtag
);

  logic grant;
  // a ready port while blocked either takes the held request or finds the slot empty
  assign grant = blocked && port_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= 1'b0;
      blocked <= 1'b0;
      addr    <= '0;
      tid     <= '0;
      rtag    <= '0;
    end else if (load) begin
      held    <= 1'b1;
      blocked <= 1'b1;
      addr    <= load_addr;
      tid     <= load_tid;
      rtag    <= load_rtag;
    end else begin
      if (grant || drop) held <= 1'b0;
      if (grant)         blocked <= 1'b0;
    end
  end

endmodule

// File: rtl/fl_thread_ctl.sv
module fl_thread_ctl
  import fetch_line_pkg::*;
#(
  parameter int RTAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_ok,
  input  logic              issue_bad,
  input  logic              retry_ok,
  input  logic              squash,
  input  logic              rsp_ok,
  output thr_state_e        state_o,
  output logic [RTAG_W-1:0] rtag_o,
  output logic              fault_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_o <= TS_READY;
      rtag_o  <= '0;
      fault_o <= 1'b0;
    end else begin
      if (issue) rtag_o <= rtag_o + RTAG_W'(1);
      if (squash) begin
        state_o <= TS_READY;
        fault_o <= 1'b0;
      end else if (issue) begin
        if (issue_ok)       state_o <= TS_WAIT_RSP;
        else if (issue_bad) state_o <= TS_READY;
        else                state_o <= TS_WAIT_RETRY;
        fault_o <= !issue_ok && issue_bad;
      end else if (retry_ok) begin
        state_o <= TS_WAIT_RSP;
      end else if (rsp_ok) begin
        state_o <= TS_READY;
      end
    end
  end

endmodule

// File: rtl/fetch_line_requester.sv
module fetch_line_requester
  import fetch_line_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int RTAG_W      = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int LINE_W     = LINE_BYTES * 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     switched_out,
  input  logic                     intr_pending,
  input  logic                     fetch_valid,
  input  logic [TID_W-1:0]         fetch_tid,
  input  logic [ADDR_W-1:0]        fetch_pc,
  output logic                     fetch_hit,
  output logic                     fetch_gated,
  output logic [LINE_W-1:0]        fetch_line,
  input  logic                     squash_valid,
  input  logic [TID_W-1:0]         squash_tid,
  output logic                     mem_req_valid,
  output logic [ADDR_W-1:0]        mem_req_addr,
  output logic [TID_W-1:0]         mem_req_tid,
  output logic [RTAG_W-1:0]        mem_req_rtag,
  input  logic                     mem_req_ready,
  input  logic                     mem_req_bad,
  input  logic                     mem_rsp_valid,
  input  logic [TID_W-1:0]         mem_rsp_tid,
  input  logic [RTAG_W-1:0]        mem_rsp_rtag,
  input  logic [LINE_W-1:0]        mem_rsp_data,
  output logic                     cache_blocked,
  output logic [2*NUM_THREADS-1:0] thread_state,
  output logic [NUM_THREADS-1:0]   line_valid,
  output logic [NUM_THREADS-1:0]   thread_fault,
  output logic                     rsp_dropped
);

  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] pc);
    return pc & ~OFF_MASK;
  endfunction

  // named internal events
  logic                                issue_new, retry_send, retry_acc, rsp_accept;
  logic                                lookup_ok, squash_fetch_thr, squash_slot_thr;
  logic [ADDR_W-1:0]                   aligned_pc;
  thr_state_e                          st     [NUM_THREADS];
  logic [RTAG_W-1:0]                   rtag   [NUM_THREADS];
  logic [NUM_THREADS-1:0][ADDR_W-1:0]  buf_tag;
  logic [NUM_THREADS-1:0][LINE_W-1:0]  buf_data;
  logic                                slot_held;
  logic [ADDR_W-1:0]                   slot_addr;
  logic [TID_W-1:0]                    slot_tid;
  logic [RTAG_W-1:0]                   slot_rtag;
  logic [RTAG_W-1:0]                   new_rtag;

  assign aligned_pc       = line_base(fetch_pc);
  assign squash_fetch_thr = squash_valid && (squash_tid == fetch_tid);
  assign squash_slot_thr  = squash_valid && (squash_tid == slot_tid);

  assign fetch_gated = fetch_valid &&
                       (cache_blocked || switched_out || intr_hold(intr_pending, fetch_pc[1:0]));
  assign lookup_ok   = fetch_valid && !fetch_gated && (st[fetch_tid] == TS_READY) && !squash_fetch_thr;
  assign fetch_hit   = lookup_ok && line_valid[fetch_tid] && (buf_tag[fetch_tid] == aligned_pc);
  assign issue_new   = lookup_ok && !fetch_hit;
  assign fetch_line  = buf_data[fetch_tid];
  assign new_rtag    = rtag[fetch_tid] + RTAG_W'(1);

  assign retry_send = cache_blocked && slot_held && !squash_slot_thr;
  assign retry_acc  = retry_send && mem_req_ready;

  assign mem_req_valid = issue_new || retry_send;
  assign mem_req_addr  = retry_send ? slot_addr : aligned_pc;
  assign mem_req_tid   = retry_send ? slot_tid  : fetch_tid;
  assign mem_req_rtag  = retry_send ? slot_rtag : new_rtag;

  assign rsp_accept  = mem_rsp_valid && (st[mem_rsp_tid] == TS_WAIT_RSP) &&
                       (mem_rsp_rtag == rtag[mem_rsp_tid]) &&
                       !(squash_valid && (squash_tid == mem_rsp_tid));
  assign rsp_dropped = mem_rsp_valid && !rsp_accept;

  fl_line_store #(
    .NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .TID_W(TID_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .inv_en(issue_new), .inv_tid(fetch_tid), .inv_addr(aligned_pc),
    .fill_en(rsp_accept), .fill_tid(mem_rsp_tid), .fill_data(mem_rsp_data),
    .tag_o(buf_tag), .valid_o(line_valid), .data_o(buf_data)
  );

  fl_retry_slot #(.ADDR_W(ADDR_W), .TID_W(TID_W), .RTAG_W(RTAG_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .load(issue_new && !mem_req_ready && !mem_req_bad),
    .load_addr(aligned_pc), .load_tid(fetch_tid), .load_rtag(new_rtag),
    .drop(squash_slot_thr), .port_ready(mem_req_ready),
    .held(slot_held), .blocked(cache_blocked),
    .addr(slot_addr), .tid(slot_tid), .rtag(slot_rtag)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    fl_thread_ctl #(.RTAG_W(RTAG_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .issue(issue_new && (fetch_tid == TID_W'(t))),
      .issue_ok(mem_req_ready),
      .issue_bad(mem_req_bad),
      .retry_ok(retry_acc && (slot_tid == TID_W'(t))),
      .squash(squash_valid && (squash_tid == TID_W'(t))),
      .rsp_ok(rsp_accept && (mem_rsp_tid == TID_W'(t))),
      .state_o(st[t]), .rtag_o(rtag[t]), .fault_o(thread_fault[t])
    );
    assign thread_state[2*t +: 2] = st[t];
  end

endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int TID_W       = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fetch_hit,
  input logic                   issue_new,
  input logic                   cache_blocked,
  input logic                   mem_req_valid,
  input logic [ADDR_W-1:0]      mem_req_addr,
  input logic                   mem_req_ready,
  input logic                   mem_req_bad,
  input logic                   mem_rsp_valid,
  input logic [TID_W-1:0]       mem_rsp_tid,
  input logic                   rsp_accept,
  input logic                   rsp_dropped,
  input logic [NUM_THREADS-1:0] line_valid
);

  localparam logic [ADDR_W-1:0] LOW_BITS = ADDR_W'(LINE_BYTES - 1);

  // R1
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_addr & LOW_BITS) == '0));

  // R2
  hit_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hit |-> !issue_new);

  // R3
  blocked_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_blocked |-> !issue_new);

  // R5
  refuse_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_new && !mem_req_ready && !mem_req_bad) |=> cache_blocked);

  // R6
  ready_unblocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_blocked && mem_req_ready) |=> !cache_blocked);

  // R8
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept |=> line_valid[$past(mem_rsp_tid)]);

  // R9
  drop_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_dropped |-> (mem_rsp_valid && !rsp_accept));

endmodule

bind fetch_line_requester fl_checker #(
  .NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_hit(fetch_hit), .issue_new(issue_new),
  .cache_blocked(cache_blocked), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
  .mem_req_ready(mem_req_ready), .mem_req_bad(mem_req_bad), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_tid(mem_rsp_tid), .rsp_accept(rsp_accept), .rsp_dropped(rsp_dropped),
  .line_valid(line_valid)
);

// File: tb/fetch_line_requester_test.sv
module fetch_line_requester_test;
  localparam int NT = 2, AW = 32, LB = 16, LW = 128, RW = 4;

  logic clk = 0, rst_n = 0;
  logic switched_out, intr_pending, fetch_valid, squash_valid;
  logic [0:0] fetch_tid, squash_tid, mem_req_tid, mem_rsp_tid;
  logic [AW-1:0] fetch_pc, mem_req_addr;
  logic fetch_hit, fetch_gated, mem_req_valid, mem_req_ready, mem_req_bad;
  logic [LW-1:0] fetch_line, mem_rsp_data;
  logic [RW-1:0] mem_req_rtag, mem_rsp_rtag;
  logic mem_rsp_valid, cache_blocked, rsp_dropped;
  logic [2*NT-1:0] thread_state;
  logic [NT-1:0] line_valid, thread_fault;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "reset";

  // reference model state
  int m_st[NT], m_rt[NT];
  bit m_lv[NT], m_flt[NT];
  logic [AW-1:0] m_lt[NT];
  logic [LW-1:0] m_ld[NT];
  bit m_blk, m_held;
  logic [AW-1:0] m_sa;
  int m_stid, m_stag;

  always #5 clk = ~clk;

  fetch_line_requester #(.NUM_THREADS(NT), .ADDR_W(AW), .LINE_BYTES(LB), .RTAG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .switched_out(switched_out), .intr_pending(intr_pending),
    .fetch_valid(fetch_valid), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc),
    .fetch_hit(fetch_hit), .fetch_gated(fetch_gated), .fetch_line(fetch_line),
    .squash_valid(squash_valid), .squash_tid(squash_tid),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_tid(mem_req_tid),
    .mem_req_rtag(mem_req_rtag), .mem_req_ready(mem_req_ready), .mem_req_bad(mem_req_bad),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tid(mem_rsp_tid), .mem_rsp_rtag(mem_rsp_rtag),
    .mem_rsp_data(mem_rsp_data), .cache_blocked(cache_blocked), .thread_state(thread_state),
    .line_valid(line_valid), .thread_fault(thread_fault), .rsp_dropped(rsp_dropped)
  );

  task automatic chk(string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s [%s]: actual %0h expected %0h", req, what, phase, act, exp);
    end
  endtask

  task automatic clr();
    switched_out = 0; intr_pending = 0; fetch_valid = 0; fetch_tid = 0; fetch_pc = 0;
    squash_valid = 0; squash_tid = 0; mem_req_ready = 1; mem_req_bad = 0;
    mem_rsp_valid = 0; mem_rsp_tid = 0; mem_rsp_rtag = 0; mem_rsp_data = 0;
  endtask

  task automatic fetch(int t, logic [AW-1:0] pc);
    fetch_valid = 1; fetch_tid = 1'(t); fetch_pc = pc;
  endtask

  task automatic rsp(int t, int tag, logic [LW-1:0] d);
    mem_rsp_valid = 1; mem_rsp_tid = 1'(t); mem_rsp_rtag = RW'(tag); mem_rsp_data = d;
  endtask

  task automatic sq(int t);
    squash_valid = 1; squash_tid = 1'(t);
  endtask

  task automatic model_reset();
    for (int i = 0; i < NT; i++) begin
      m_st[i] = 0; m_rt[i] = 0; m_lv[i] = 0; m_flt[i] = 0; m_lt[i] = 0; m_ld[i] = 0;
    end
    m_blk = 0; m_held = 0; m_sa = 0; m_stid = 0; m_stag = 0;
  endtask

  // one clock: compare outputs against the model, then advance the model
  task automatic tick();
    int t, rt;
    bit gated, cand, e_hit, e_new, e_retry, e_acc, e_mv;
    logic [AW-1:0] al;
    #1;
    t  = int'(fetch_tid);
    rt = int'(mem_rsp_tid);
    al = fetch_pc - (fetch_pc % LB);
    gated = m_blk || switched_out || (intr_pending && (fetch_pc % 4 == 0));
    cand  = fetch_valid && !gated && m_st[t] == 0 && !(squash_valid && int'(squash_tid) == t);
    e_hit = cand && m_lv[t] && m_lt[t] == al;
    e_new = cand && !e_hit;
    e_retry = m_blk && m_held && !(squash_valid && int'(squash_tid) == m_stid);
    e_mv  = e_new || e_retry;
    e_acc = mem_rsp_valid && m_st[rt] == 2 && int'(mem_rsp_rtag) == m_rt[rt] &&
            !(squash_valid && int'(squash_tid) == rt);

    chk("R4", "mem_req_valid", LW'(mem_req_valid), LW'(e_mv));
    if (e_mv) begin
      chk("R1", "mem_req_addr", LW'(mem_req_addr), LW'(e_retry ? m_sa : al));
      chk("R6", "mem_req_tid", LW'(mem_req_tid), LW'(e_retry ? m_stid : t));
      chk("R4", "mem_req_rtag", LW'(mem_req_rtag), LW'(e_retry ? m_stag : (m_rt[t] + 1) % 16));
    end
    chk("R2", "fetch_hit", LW'(fetch_hit), LW'(e_hit));
    chk("R3", "fetch_gated", LW'(fetch_gated), LW'(fetch_valid && gated));
    if (e_hit) chk("R8", "fetch_line", fetch_line, m_ld[t]);
    chk("R9", "rsp_dropped", LW'(rsp_dropped), LW'(mem_rsp_valid && !e_acc));
    chk("R5", "cache_blocked", LW'(cache_blocked), LW'(m_blk));
    for (int i = 0; i < NT; i++) begin
      chk("R6", "thread_state", LW'(thread_state[2*i +: 2]), LW'(m_st[i]));
      chk("R8", "line_valid", LW'(line_valid[i]), LW'(m_lv[i]));
      chk("R10", "thread_fault", LW'(thread_fault[i]), LW'(m_flt[i]));
    end

    @(posedge clk);
    for (int i = 0; i < NT; i++)
      if (squash_valid && int'(squash_tid) == i) begin m_st[i] = 0; m_flt[i] = 0; end
    if (e_new) begin
      m_rt[t] = (m_rt[t] + 1) % 16;
      m_lt[t] = al; m_lv[t] = 0;
      m_st[t] = mem_req_ready ? 2 : (mem_req_bad ? 0 : 1);
      m_flt[t] = !mem_req_ready && mem_req_bad;
    end
    if (e_retry && mem_req_ready) m_st[m_stid] = 2;
    if (e_acc) begin m_st[rt] = 0; m_lv[rt] = 1; m_ld[rt] = mem_rsp_data; end
    if (e_new && !mem_req_ready && !mem_req_bad) begin
      m_held = 1; m_blk = 1; m_sa = al; m_stid = t; m_stag = m_rt[t];
    end else begin
      if (squash_valid && int'(squash_tid) == m_stid) m_held = 0;
      if (m_blk && mem_req_ready) begin m_held = 0; m_blk = 0; end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    phase = "reset"; clr(); tick(); tick();
    phase = "R1 R4 miss issue"; clr(); fetch(0, 32'h104); tick();
    phase = "R8 fill"; clr(); rsp(0, m_rt[0], 128'hD0D0_0001); tick();
    phase = "R2 hit"; clr(); fetch(0, 32'h10C); tick(); clr(); fetch(0, 32'h101); tick();
    phase = "R5 refuse"; clr(); mem_req_ready = 0; fetch(0, 32'h118); tick();
    phase = "R3 blocked"; clr(); mem_req_ready = 0; fetch(1, 32'h204); tick(); tick();
    phase = "R6 retry grant"; clr(); tick();
    phase = "R9 wrong tag"; clr(); rsp(0, (m_rt[0] + 1) % 16, 128'hBAD); tick();
    phase = "R9 wrong thread"; clr(); rsp(1, m_rt[1], 128'hBAD); tick();
    phase = "R8 fill2"; clr(); rsp(0, m_rt[0], 128'hD1D1_0002); tick();
    phase = "R3 interrupt"; clr(); intr_pending = 1; fetch(1, 32'h300); tick();
    clr(); intr_pending = 1; fetch(1, 32'h302); tick();
    phase = "R11 busy thread"; clr(); fetch(1, 32'h302); tick();
    phase = "R11 same-cycle squash"; clr(); fetch(0, 32'h500); sq(0); tick();
    phase = "R8 issue and fill together"; clr(); rsp(1, m_rt[1], 128'hD2D2_0003);
    fetch(0, 32'h600); tick();
    phase = "R3 switched out"; clr(); switched_out = 1; fetch(1, 32'h304); tick();
    phase = "R2 hit after fill"; clr(); fetch(1, 32'h304); tick();
    phase = "R7 squash with response"; clr(); sq(0); rsp(0, m_rt[0], 128'hD3); tick();
    phase = "R7 late response"; clr(); rsp(0, m_rt[0], 128'hD3); tick();
    phase = "R7 squash empties slot"; clr(); mem_req_ready = 0; fetch(0, 32'h700); tick();
    clr(); mem_req_ready = 0; sq(0); tick();
    clr(); mem_req_ready = 0; tick();
    clr(); tick(); tick();
    phase = "R7 squash at grant"; clr(); mem_req_ready = 0; fetch(1, 32'h800); tick();
    clr(); sq(1); tick(); clr(); tick();
    phase = "R10 bad address"; clr(); mem_req_ready = 0; mem_req_bad = 1; fetch(1, 32'h900); tick();
    clr(); tick(); clr(); fetch(1, 32'h904); tick();
    clr(); mem_req_ready = 0; mem_req_bad = 1; fetch(0, 32'hA00); tick();
    clr(); sq(0); tick(); clr(); tick();
    phase = "R4 tag wrap";
    for (int i = 0; i < 18; i++) begin
      clr(); fetch(0, 32'h1000 + i * 16); tick();
      clr(); rsp(0, m_rt[0], LW'(i) + 128'h5000); tick();
      clr(); fetch(0, 32'h1000 + i * 16 + 6); tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule